// File: doc/BRIEF.md
# Dual-Rank DRAM Command Decoder

This block sits on the device side of a two-rank DDR3-style command interface. On every rising clock edge it captures the per-rank chip selects and clock enables, the shared RAS#/CAS#/WE# lines, the shared bank lines and the shared address bus. From the captured values it decodes one command and routes it to the selected rank as a single-cycle strobe. It also presents the address fields that go with that command: bank, row or op-code, column, auto-precharge, precharge-all, burst chop and mode-register index.

Each rank keeps three pieces of state: which of its eight banks hold an open row, whether on-the-fly burst chop has been enabled through a mode-register load, and a power state driven by its clock enable. A protocol error flag is raised per rank when a row is activated in a bank that is already open, or when a read or write targets a closed bank. If both chip selects are low in the same cycle, the command is flagged as a clash and dropped for both ranks. Timing parameters are not enforced here. A downstream bank model or a protocol monitor consumes the strobes.

Top module: `dual_rank_cmd_decoder`

## Requirements
- R1: Inputs are registered, and the decoded strobes appear in the cycle after the capturing edge. With a rank's chip select low, {RAS#,CAS#,WE#} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 load mode, 111 no-op. The code 110 raises no strobe.
- R2: A rank whose captured chip select is high gets no strobe, and its state does not change.
- R3: When both chip selects are captured low, clash_o is high and neither rank gets a strobe or a state change.
- R4: In a precharge, A10 low closes only the bank on BA, and A10 high closes every bank of that rank. pre_all_o equals A10 during a precharge strobe and is 0 otherwise.
- R5: In a read or write, ap_o equals A10. When A10 is high, the addressed bank is closed after the access.
- R6: A load mode to mode register 0 (BA = 0) enables on-the-fly burst chop for that rank when A[1:0] = 01, and disables it for any other value. When enabled, bc4_o is high on a read or write with A12 low. When disabled, A12 is ignored and bc4_o stays 0. Burst chop is disabled after reset.
- R7: mr_sel_o carries BA[1:0], and row_o carries A[15:0], which serves as the op-code during a load mode.
- R8: bank_o carries BA. col_o is {A11, A[9:0]} for the x4 column variant and {0, A[9:0]} for the x8 variant.
- R9: An activate marks its bank open. err_o is high for an activate to an open bank and for a read or write to a closed bank.
- R10: Power state per rank in pwr_o[2r+1:2r] uses the codes 0 awake, 1 precharge power-down, 2 active power-down, 3 self refresh. The rules are:
  - While awake, a captured low clock enable moves the rank to self refresh if a refresh is selected for it in that cycle.
  - Otherwise the rank moves to precharge power-down if no bank is open, and to active power-down if any bank is open.
  - A captured high clock enable returns the rank to awake.
  - No command is accepted while the clock enable is low or the rank is not awake.
- R11: After reset all strobes, err_o and clash_o are 0, every rank is awake with all banks closed, and burst chop is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | NRANK | Per-rank chip select, active low |
| cke_i | input | NRANK | Per-rank clock enable |
| ras_n_i | input | 1 | Row strobe command line |
| cas_n_i | input | 1 | Column strobe command line |
| we_n_i | input | 1 | Write-enable command line |
| addr_i | input | ROWW | Shared address bus |
| ba_i | input | BAW | Shared bank address |
| act_o | output | NRANK | Activate strobe per rank |
| rd_o | output | NRANK | Read strobe per rank |
| wr_o | output | NRANK | Write strobe per rank |
| pre_o | output | NRANK | Precharge strobe per rank |
| lmr_o | output | NRANK | Load-mode strobe per rank |
| ref_o | output | NRANK | Refresh strobe per rank |
| nop_o | output | NRANK | No-op strobe per rank |
| err_o | output | NRANK | Open/closed bank protocol error per rank |
| clash_o | output | 1 | Both chip selects low |
| bc4_o | output | 1 | Burst chop of 4 for the current access |
| ap_o | output | 1 | Auto-precharge on the current access |
| pre_all_o | output | 1 | Precharge covers all banks |
| bank_o | output | BAW | Captured bank address |
| row_o | output | ROWW | Captured row address or op-code |
| col_o | output | 11 | Column address |
| mr_sel_o | output | 2 | Mode register index |
| pwr_o | output | 2*NRANK | Power state per rank |

## Verification
Two functions can fall in the same cycle. The first is a refresh selected for a rank while that rank's clock enable is captured low: it must move the rank into self refresh instead of raising a refresh strobe. The second is a precharge or auto-precharge, which changes the open-bank vector that power-down entry consults. The bench issues refresh, precharge-all and activate commands with the clock enable held low or just raised. It then judges the result from the reported power code and from whether later activates and reads flag err_o. A reference model in the bench tracks open banks, burst-chop enable and power state per rank. The model predicts every output for a sweep over all chip-select pairs, all command codes and all banks.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_RSV = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        PS_AWAKE = 2'd0,
        PS_PPD   = 2'd1,
        PS_APD   = 2'd2,
        PS_SREF  = 2'd3
    } pwr_e;
endpackage

// File: rtl/rcd_decode.sv
module rcd_decode
    import rcd_pkg::*;
#(
    parameter int NRANK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NRANK-1:0] cs_n,
    input  logic [2:0]       code,
    output logic [NRANK-1:0] sel,
    output logic             clash,
    output cmd_e             cmd
);
    always_comb begin
        clash = ($countones(~cs_n) > 1);
        sel   = clash ? '0 : ~cs_n;
        cmd   = cmd_e'(code);
    end

    // R3: at most one rank is ever handed a command
    p_one_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/rcd_rank.sv
module rcd_rank
    import rcd_pkg::*;
#(
    parameter int NBANK = 8,
    localparam int BAW = $clog2(NBANK)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           cke,
    input  cmd_e           cmd,
    input  logic [BAW-1:0] ba,
    input  logic           a10,
    input  logic           a12,
    input  logic [1:0]     mode,
    output logic           act,
    output logic           rd,
    output logic           wr,
    output logic           pre,
    output logic           lmr,
    output logic           refr,
    output logic           nop,
    output logic           err,
    output logic           bc4,
    output pwr_e           ps
);
    typedef struct packed {
        logic [NBANK-1:0] open;
        logic             otf;
        pwr_e             ps;
    } state_t;

    state_t st_d, st_q;
    logic   go;
    logic   hit;

    always_comb begin
        go   = sel && cke && (st_q.ps == PS_AWAKE);
        act  = go && (cmd == CMD_ACT);
        rd   = go && (cmd == CMD_RD);
        wr   = go && (cmd == CMD_WR);
        pre  = go && (cmd == CMD_PRE);
        lmr  = go && (cmd == CMD_LMR);
        refr = go && (cmd == CMD_REF);
        nop  = go && (cmd == CMD_NOP);
        hit  = st_q.open[ba];
        err  = (act && hit) || ((rd || wr) && !hit);
        bc4  = (rd || wr) && st_q.otf && !a12;
        ps   = st_q.ps;

        st_d = st_q;
        if (act) st_d.open[ba] = 1'b1;
        if (pre) begin
            if (a10) st_d.open = '0;
            else     st_d.open[ba] = 1'b0;
        end
        if ((rd || wr) && a10) st_d.open[ba] = 1'b0;
        if (lmr && (ba == '0)) st_d.otf = (mode == 2'b01);

        if ((st_q.ps == PS_AWAKE) && !cke) begin
            if (sel && (cmd == CMD_REF)) st_d.ps = PS_SREF;
            else if (st_q.open == '0)    st_d.ps = PS_PPD;
            else                         st_d.ps = PS_APD;
        end else if ((st_q.ps != PS_AWAKE) && cke) begin
            st_d.ps = PS_AWAKE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{open: '0, otf: 1'b0, ps: PS_AWAKE};
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an unselected rank raises nothing
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !(act || rd || wr || pre || lmr || refr || nop));
    // R10: quiet while powered down
    p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ps != PS_AWAKE) |-> !(act || rd || wr || pre || lmr || refr || nop));
    // R10: refresh with clock enable low enters self refresh
    p_sref_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ps == PS_AWAKE) && !cke && sel && (cmd == CMD_REF)) |=> (st_q.ps == PS_SREF));
    // R4: precharge-all leaves no bank open
    p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && a10) |=> (st_q.open == '0));
    // R9: activated bank is open afterwards
    p_act_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> st_q.open[$past(ba)]);
    // R6: burst chop only when the mode enables it
    p_bc4_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bc4 |-> st_q.otf);
endmodule

// File: rtl/dual_rank_cmd_decoder.sv
module dual_rank_cmd_decoder
    import rcd_pkg::*;
#(
    parameter int NRANK  = 2,
    parameter int NBANK  = 8,
    parameter int ROWW   = 16,
    parameter bit X4_COL = 1'b1,
    localparam int BAW   = $clog2(NBANK),
    localparam int COLW  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NRANK-1:0]     cs_n_i,
    input  logic [NRANK-1:0]     cke_i,
    input  logic                 ras_n_i,
    input  logic                 cas_n_i,
    input  logic                 we_n_i,
    input  logic [ROWW-1:0]      addr_i,
    input  logic [BAW-1:0]       ba_i,
    output logic [NRANK-1:0]     act_o,
    output logic [NRANK-1:0]     rd_o,
    output logic [NRANK-1:0]     wr_o,
    output logic [NRANK-1:0]     pre_o,
    output logic [NRANK-1:0]     lmr_o,
    output logic [NRANK-1:0]     ref_o,
    output logic [NRANK-1:0]     nop_o,
    output logic [NRANK-1:0]     err_o,
    output logic                 clash_o,
    output logic                 bc4_o,
    output logic                 ap_o,
    output logic                 pre_all_o,
    output logic [BAW-1:0]       bank_o,
    output logic [ROWW-1:0]      row_o,
    output logic [COLW-1:0]      col_o,
    output logic [1:0]           mr_sel_o,
    output logic [2*NRANK-1:0]   pwr_o
);
    typedef struct packed {
        logic [NRANK-1:0] cs_n;
        logic [NRANK-1:0] cke;
        logic [2:0]       code;
        logic [ROWW-1:0]  a;
        logic [BAW-1:0]   ba;
    } in_t;

    in_t              in_d, in_q;
    logic [NRANK-1:0] sel;
    logic [NRANK-1:0] bc4_r;
    cmd_e             cmd;

    always_comb begin
        in_d = '{cs_n: cs_n_i, cke: cke_i, code: {ras_n_i, cas_n_i, we_n_i},
                 a: addr_i, ba: ba_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '{cs_n: '1, cke: '1, code: 3'b111, a: '0, ba: '0};
        end else begin
            in_q <= in_d;
        end
    end

    rcd_decode #(.NRANK(NRANK)) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (in_q.cs_n),
        .code  (in_q.code),
        .sel   (sel),
        .clash (clash_o),
        .cmd   (cmd)
    );

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        pwr_e ps_r;
        rcd_rank #(.NBANK(NBANK)) u_rank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel[r]),
            .cke   (in_q.cke[r]),
            .cmd   (cmd),
            .ba    (in_q.ba),
            .a10   (in_q.a[10]),
            .a12   (in_q.a[12]),
            .mode  (in_q.a[1:0]),
            .act   (act_o[r]),
            .rd    (rd_o[r]),
            .wr    (wr_o[r]),
            .pre   (pre_o[r]),
            .lmr   (lmr_o[r]),
            .refr  (ref_o[r]),
            .nop   (nop_o[r]),
            .err   (err_o[r]),
            .bc4   (bc4_r[r]),
            .ps    (ps_r)
        );
        assign pwr_o[2*r +: 2] = ps_r;
    end

    if (X4_COL) begin : g_col_x4
        assign col_o = {in_q.a[11], in_q.a[9:0]};
    end else begin : g_col_x8
        assign col_o = {1'b0, in_q.a[9:0]};
    end

    always_comb begin
        bc4_o     = |bc4_r;
        ap_o      = in_q.a[10] && |(rd_o | wr_o);
        pre_all_o = in_q.a[10] && |pre_o;
        bank_o    = in_q.ba;
        row_o     = in_q.a;
        mr_sel_o  = in_q.ba[1:0];
    end

    // R3: a clash drops the command on every rank
    p_clash_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clash_o |-> ((act_o | rd_o | wr_o | pre_o | lmr_o | ref_o | nop_o) == '0));
    // R5: auto-precharge only accompanies an access
    p_ap_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ap_o |-> |(rd_o | wr_o));
endmodule

// File: tb/dual_rank_cmd_decoder_bench.sv
`timescale 1ns/1ps
module dual_rank_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cs_n_i = 2'b11;
    logic [1:0]  cke_i = 2'b11;
    logic        ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [15:0] addr_i = '0;
    logic [2:0]  ba_i = '0;
    logic [1:0]  act_o, rd_o, wr_o, pre_o, lmr_o, ref_o, nop_o, err_o;
    logic        clash_o, bc4_o, ap_o, pre_all_o;
    logic [2:0]  bank_o;
    logic [15:0] row_o;
    logic [10:0] col_o;
    logic [1:0]  mr_sel_o;
    logic [3:0]  pwr_o;

    int checks = 0;
    int fails = 0;

    logic [7:0] open_m [2];
    logic       otf_m  [2];
    logic [1:0] ps_m   [2];

    always #2 clk = ~clk;

    dual_rank_cmd_decoder u_dual_rank_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .cke_i(cke_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .addr_i(addr_i), .ba_i(ba_i),
        .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
        .lmr_o(lmr_o), .ref_o(ref_o), .nop_o(nop_o), .err_o(err_o),
        .clash_o(clash_o), .bc4_o(bc4_o), .ap_o(ap_o), .pre_all_o(pre_all_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .mr_sel_o(mr_sel_o),
        .pwr_o(pwr_o)
    );

    task automatic step(input logic [1:0] cs, input logic [1:0] ck,
                        input logic [2:0] c, input logic [2:0] b,
                        input logic [15:0] a, input string tag);
        logic [1:0] e_act, e_rd, e_wr, e_pre, e_lmr, e_ref, e_nop, e_err;
        logic       e_clash, e_bc4, e_ap, e_pall;
        logic [3:0] e_pwr;
        logic [1:0] sel;
        logic [55:0] got, exp;
        cs_n_i = cs; cke_i = ck; {ras_n_i, cas_n_i, we_n_i} = c;
        ba_i = b; addr_i = a;
        @(negedge clk);
        e_clash = (cs == 2'b00);
        e_bc4 = 1'b0;
        e_pwr = {ps_m[1], ps_m[0]};
        for (int r = 0; r < 2; r++) begin
            logic go;
            sel[r] = !cs[r] && !e_clash;
            go = sel[r] && ck[r] && (ps_m[r] == 2'd0);
            e_act[r] = go && (c == 3'b011);
            e_rd[r]  = go && (c == 3'b101);
            e_wr[r]  = go && (c == 3'b100);
            e_pre[r] = go && (c == 3'b010);
            e_lmr[r] = go && (c == 3'b000);
            e_ref[r] = go && (c == 3'b001);
            e_nop[r] = go && (c == 3'b111);
            e_err[r] = (e_act[r] && open_m[r][b]) || ((e_rd[r] || e_wr[r]) && !open_m[r][b]);
            if ((e_rd[r] || e_wr[r]) && otf_m[r] && !a[12]) e_bc4 = 1'b1;
        end
        e_ap   = a[10] && |(e_rd | e_wr);
        e_pall = a[10] && |e_pre;
        exp = {e_act, e_rd, e_wr, e_pre, e_lmr, e_ref, e_nop, e_err,
               e_clash, e_bc4, e_ap, e_pall, e_pwr, b, a, a[11], a[9:0], b[1:0]};
        got = {act_o, rd_o, wr_o, pre_o, lmr_o, ref_o, nop_o, err_o,
               clash_o, bc4_o, ap_o, pre_all_o, pwr_o, bank_o, row_o, col_o, mr_sel_o};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
        for (int r = 0; r < 2; r++) begin
            if (ps_m[r] == 2'd0 && !ck[r]) begin
                if (sel[r] && c == 3'b001) ps_m[r] = 2'd3;
                else if (open_m[r] == 8'h00) ps_m[r] = 2'd1;
                else ps_m[r] = 2'd2;
            end else if (ps_m[r] != 2'd0 && ck[r]) begin
                ps_m[r] = 2'd0;
            end
            if (e_act[r]) open_m[r][b] = 1'b1;
            if (e_pre[r]) begin
                if (a[10]) open_m[r] = 8'h00;
                else open_m[r][b] = 1'b0;
            end
            if ((e_rd[r] || e_wr[r]) && a[10]) open_m[r][b] = 1'b0;
            if (e_lmr[r] && b == 3'd0) otf_m[r] = (a[1:0] == 2'b01);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 2; r++) begin
            open_m[r] = '0; otf_m[r] = 1'b0; ps_m[r] = 2'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step(2'b11, 2'b11, 3'b111, 3'd0, 16'h0000, "R11");

        // near-exhaustive sweep: chip-select pairs x command codes x banks
        for (int cs = 0; cs < 4; cs++) begin
            for (int c = 0; c < 8; c++) begin
                for (int b = 0; b < 8; b++) begin
                    logic [15:0] a;
                    string tg;
                    a = 16'(b * 4099 + c * 517 + cs * 9001);
                    if (cs == 0) tg = "R3";
                    else if (cs == 3) tg = "R2";
                    else if (c == 3) tg = "R9";
                    else if (c == 5 || c == 4) tg = "R5";
                    else if (c == 2) tg = "R4";
                    else if (c == 0) tg = "R7";
                    else tg = "R1";
                    step(2'(cs), 2'b11, 3'(c), 3'(b), a, tg);
                    step(2'(cs), 2'b11, 3'(c), 3'(b), a ^ 16'h0400, tg);
                end
            end
        end

        // burst chop enable and disable, per rank
        step(2'b10, 2'b11, 3'b010, 3'd0, 16'h0400, "R4");
        step(2'b10, 2'b11, 3'b000, 3'd0, 16'h0001, "R6");
        step(2'b10, 2'b11, 3'b011, 3'd2, 16'h1234, "R9");
        step(2'b10, 2'b11, 3'b101, 3'd2, 16'h0000, "R6");
        step(2'b10, 2'b11, 3'b100, 3'd2, 16'h1000, "R6");
        step(2'b01, 2'b11, 3'b000, 3'd0, 16'h0002, "R6");
        step(2'b01, 2'b11, 3'b011, 3'd2, 16'h0000, "R9");
        step(2'b01, 2'b11, 3'b101, 3'd2, 16'h0000, "R6");
        step(2'b10, 2'b11, 3'b000, 3'd1, 16'h0000, "R6");
        step(2'b10, 2'b11, 3'b101, 3'd2, 16'h0000, "R6");
        step(2'b10, 2'b11, 3'b000, 3'd0, 16'h0000, "R6");
        step(2'b10, 2'b11, 3'b101, 3'd2, 16'h0400, "R6");
        step(2'b10, 2'b11, 3'b101, 3'd2, 16'h0000, "R9");

        // column field variants
        step(2'b10, 2'b11, 3'b011, 3'd6, 16'hFFFF, "R8");
        step(2'b10, 2'b11, 3'b100, 3'd6, 16'h0BFF, "R8");
        step(2'b10, 2'b11, 3'b101, 3'd6, 16'h0A55, "R8");

        // power states
        step(2'b10, 2'b11, 3'b010, 3'd0, 16'h0400, "R4");
        step(2'b01, 2'b11, 3'b010, 3'd0, 16'h0400, "R4");
        step(2'b11, 2'b10, 3'b111, 3'd0, 16'h0000, "R10");
        step(2'b10, 2'b10, 3'b011, 3'd1, 16'h0000, "R10");
        step(2'b10, 2'b11, 3'b011, 3'd1, 16'h0000, "R10");
        step(2'b10, 2'b11, 3'b011, 3'd5, 16'h0000, "R10");
        step(2'b10, 2'b11, 3'b101, 3'd1, 16'h0000, "R10");
        step(2'b11, 2'b10, 3'b111, 3'd0, 16'h0000, "R10");
        step(2'b10, 2'b10, 3'b010, 3'd5, 16'h0400, "R10");
        step(2'b11, 2'b11, 3'b111, 3'd0, 16'h0000, "R10");
        step(2'b10, 2'b11, 3'b011, 3'd5, 16'h0000, "R10");
        step(2'b10, 2'b11, 3'b010, 3'd5, 16'h0400, "R10");
        step(2'b10, 2'b10, 3'b001, 3'd0, 16'h0000, "R10");
        step(2'b10, 2'b10, 3'b001, 3'd0, 16'h0000, "R10");
        step(2'b11, 2'b11, 3'b111, 3'd0, 16'h0000, "R10");
        step(2'b01, 2'b01, 3'b001, 3'd0, 16'h0000, "R10");
        step(2'b00, 2'b01, 3'b001, 3'd0, 16'h0000, "R10");
        step(2'b11, 2'b11, 3'b111, 3'd0, 16'h0000, "R10");
        step(2'b01, 2'b11, 3'b001, 3'd0, 16'h0000, "R1");
        step(2'b10, 2'b11, 3'b110, 3'd0, 16'h0000, "R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule